// File: doc/BRIEF.md
# MSI Doorbell Interrupt Controller

This block turns message-signalled interrupts from PCIe endpoints into one level-sensitive interrupt for the host processor. Endpoints signal by posting a 32-bit write to a single programmable 64-bit doorbell address. The block watches the stream of inbound writes. When a write hits the doorbell, the block takes the written data value as a vector number and latches that vector's pending bit. Writes that miss the doorbell are left alone. The snoop port carries only writes, so reads of the doorbell address never reach the block and go on as ordinary reads.

Software sets the block up through a 32-bit register port. It programs the doorbell address in two halves, chooses which of the 32 vectors may capture (enable), chooses which pending vectors may raise the interrupt (mask), and acknowledges vectors by writing ones to the pending register. The doorbell window is live only while at least one vector is enabled. When a write is claimed as a doorbell, the block reports it on a one-cycle hit pulse so the surrounding fabric can drop it.

Top module: `msi_doorbell_ctrl`

## Requirements
- R1: After a synchronous reset, every register (doorbell address, enable, mask, pending) reads zero, `irq_o` is low and the doorbell window is closed.
- R2: A doorbell hit with data value N (N < 32) sets pending bit N at the next clock edge, but only if enable bit N is 1. A hit on an N whose enable bit is 0 sets nothing.
- R3: `irq_o` is a register that is high exactly one cycle after (pending AND NOT mask) is nonzero. It goes low on the cycle after that term becomes zero, whether the bits were acknowledged or masked.
- R4: A mask bit only gates the interrupt. A masked vector still captures its pending bit, and unmasking it later raises `irq_o`.
- R5: The window decodes only while the enable register is nonzero. With enable at zero, a write to the doorbell address gives no `snp_hit_o` and changes no pending bit.
- R6: A hit needs all four byte strobes set, snoop address bits 1:0 equal to 00, and snoop address bits 63:2 equal to the programmed address bits 63:2. Bits 1:0 of the programmed address take no part in the match. Any other write, including one to the neighbouring word, is ignored.
- R7: The doorbell address is written as two independent halves: offset 0x820 holds bits 31:0 and offset 0x824 holds bits 63:32. Each write replaces only its own half.
- R8: A doorbell hit whose data value is 32 or more still pulses `snp_hit_o` but sets no pending bit.
- R9: The pending register at offset 0x830 is write-one-to-clear. Each 1 in the write data clears that bit, and each 0 leaves its bit unchanged.
- R10: If a doorbell hit sets bit N in the same cycle that software clears bit N, the bit ends up set.
- R11: A read strobe returns data on `cfg_rdata_o` one cycle later. The offsets are 0x820 (address low), 0x824 (address high), 0x828 (enable), 0x82C (mask) and 0x830 (pending). Any other offset reads zero.
- R12: `snp_hit_o` is a one-cycle pulse, registered one cycle after each snoop beat that hits the doorbell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr_i | input | 12 | Register byte offset |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_re_i | input | 1 | Register read strobe |
| cfg_rdata_o | output | 32 | Register read data, one cycle after the strobe |
| snp_addr_i | input | 64 | Inbound write address |
| snp_data_i | input | 32 | Inbound write data |
| snp_be_i | input | 4 | Inbound write byte strobes |
| snp_valid_i | input | 1 | Inbound write beat valid |
| snp_hit_o | output | 1 | Beat was claimed as a doorbell write |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
The assertions assume that each snoop beat is a single write held for exactly one cycle and that a register write and a register read never target the same offset in the same cycle. The bench keeps to this. It drives every snoop beat and register strobe for exactly one clock, changes inputs only on the falling edge, and overlaps a register write with a doorbell beat only in the one test that checks simultaneous set and clear.

// File: rtl/msi_doorbell_pkg.sv
package msi_doorbell_pkg;

  // Register port data width.
  localparam int unsigned REG_W = 32;

  // Register offsets. Software drivers decode these, so they are kept fixed.
  localparam logic [11:0] OFS_DB_LO  = 12'h820;
  localparam logic [11:0] OFS_DB_HI  = 12'h824;
  localparam logic [11:0] OFS_ENABLE = 12'h828;
  localparam logic [11:0] OFS_MASK   = 12'h82C;
  localparam logic [11:0] OFS_STATUS = 12'h830;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DB_LO,
    SEL_DB_HI,
    SEL_ENABLE,
    SEL_MASK,
    SEL_STATUS
  } reg_sel_e;

  function automatic reg_sel_e decode_offset(input logic [11:0] ofs);
    case (ofs)
      OFS_DB_LO:  return SEL_DB_LO;
      OFS_DB_HI:  return SEL_DB_HI;
      OFS_ENABLE: return SEL_ENABLE;
      OFS_MASK:   return SEL_MASK;
      OFS_STATUS: return SEL_STATUS;
      default:    return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
  import msi_doorbell_pkg::*;
#(
  parameter int unsigned CFG_AW  = 12,
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned NUM_VEC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CFG_AW-1:0]  cfg_addr_i,
  input  logic [REG_W-1:0]   cfg_wdata_i,
  input  logic               cfg_we_i,
  input  logic               cfg_re_i,
  output logic [REG_W-1:0]   cfg_rdata_o,
  input  logic [NUM_VEC-1:0] status_i,
  output logic [ADDR_W-1:0]  db_addr_o,
  output logic [NUM_VEC-1:0] enable_o,
  output logic [NUM_VEC-1:0] mask_o,
  output logic [NUM_VEC-1:0] clr_vec_o
);

  localparam int unsigned HALF_W = ADDR_W / 2;

  logic [HALF_W-1:0]  db_lo_q, db_hi_q;
  logic [NUM_VEC-1:0] enable_q, mask_q;
  logic [REG_W-1:0]   rdata_q;
  reg_sel_e           sel;

  always_comb sel = decode_offset(cfg_addr_i[11:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      db_lo_q  <= '0;
      db_hi_q  <= '0;
      enable_q <= '0;
      mask_q   <= '0;
    end else if (cfg_we_i) begin
      case (sel)
        SEL_DB_LO:  db_lo_q  <= cfg_wdata_i[HALF_W-1:0];
        SEL_DB_HI:  db_hi_q  <= cfg_wdata_i[HALF_W-1:0];
        SEL_ENABLE: enable_q <= cfg_wdata_i[NUM_VEC-1:0];
        SEL_MASK:   mask_q   <= cfg_wdata_i[NUM_VEC-1:0];
        default: ;
      endcase
    end
  end

  // Write-one-to-clear request toward the vector bank.
  always_comb begin
    clr_vec_o = '0;
    if (cfg_we_i && sel == SEL_STATUS) clr_vec_o = cfg_wdata_i[NUM_VEC-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (cfg_re_i) begin
      case (sel)
        SEL_DB_LO:  rdata_q <= REG_W'(db_lo_q);
        SEL_DB_HI:  rdata_q <= REG_W'(db_hi_q);
        SEL_ENABLE: rdata_q <= REG_W'(enable_q);
        SEL_MASK:   rdata_q <= REG_W'(mask_q);
        SEL_STATUS: rdata_q <= REG_W'(status_i);
        default:    rdata_q <= '0;
      endcase
    end
  end

  assign cfg_rdata_o = rdata_q;
  assign db_addr_o   = {db_hi_q, db_lo_q};
  assign enable_o    = enable_q;
  assign mask_o      = mask_q;

  AST_HI_HALF_KEPT: assert property (@(posedge clk) disable iff (rst)
    (cfg_we_i && sel == SEL_DB_LO) |=> $stable(db_hi_q)); // R7
  AST_LO_HALF_KEPT: assert property (@(posedge clk) disable iff (rst)
    (cfg_we_i && sel == SEL_DB_HI) |=> $stable(db_lo_q)); // R7

endmodule

// File: rtl/msi_doorbell_match.sv
module msi_doorbell_match #(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_VEC = 32
) (
  input  logic [ADDR_W-1:0]   snp_addr_i,
  input  logic [DATA_W-1:0]   snp_data_i,
  input  logic [DATA_W/8-1:0] snp_be_i,
  input  logic                snp_valid_i,
  input  logic [ADDR_W-3:0]   db_word_i,
  input  logic [NUM_VEC-1:0]  enable_i,
  output logic                hit_o,
  output logic [NUM_VEC-1:0]  set_vec_o
);

  logic window_open, word_match, full_access;

  always_comb begin
    window_open = |enable_i;
    word_match  = (snp_addr_i[ADDR_W-1:2] == db_word_i);
    full_access = (&snp_be_i) && (snp_addr_i[1:0] == 2'b00);
    hit_o       = snp_valid_i && window_open && word_match && full_access;
  end

  // Per-vector decode of the data value. Values at or above NUM_VEC match nothing.
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec_dec
    assign set_vec_o[v] = hit_o && enable_i[v] && (snp_data_i == DATA_W'(v));
  end

endmodule

// File: rtl/msi_vector_bank.sv
module msi_vector_bank #(
  parameter int unsigned NUM_VEC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_VEC-1:0] set_vec_i,
  input  logic [NUM_VEC-1:0] clr_vec_i,
  input  logic [NUM_VEC-1:0] mask_i,
  output logic [NUM_VEC-1:0] status_o,
  output logic               irq_o
);

  logic [NUM_VEC-1:0] status_q;
  logic               irq_q;

  // A new event takes priority over an acknowledge in the same cycle.
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_pend
    always_ff @(posedge clk) begin
      if (rst)               status_q[v] <= 1'b0;
      else if (set_vec_i[v]) status_q[v] <= 1'b1;
      else if (clr_vec_i[v]) status_q[v] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(status_q & ~mask_i);
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (status_q & $past(clr_vec_i) & ~$past(set_vec_i)) == '0); // R9
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (~status_q & $past(set_vec_i)) == '0); // R10
  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(status_q != '0)); // R3

endmodule

// File: rtl/msi_doorbell_ctrl.sv
module msi_doorbell_ctrl
  import msi_doorbell_pkg::*;
#(
  parameter int unsigned CFG_AW  = 12,
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_VEC = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CFG_AW-1:0]   cfg_addr_i,
  input  logic [REG_W-1:0]    cfg_wdata_i,
  input  logic                cfg_we_i,
  input  logic                cfg_re_i,
  output logic [REG_W-1:0]    cfg_rdata_o,
  input  logic [ADDR_W-1:0]   snp_addr_i,
  input  logic [DATA_W-1:0]   snp_data_i,
  input  logic [DATA_W/8-1:0] snp_be_i,
  input  logic                snp_valid_i,
  output logic                snp_hit_o,
  output logic                irq_o
);

  logic [ADDR_W-1:0]  db_addr;
  logic [NUM_VEC-1:0] enable, mask, status, clr_vec, set_vec;
  logic               hit, hit_q;

  msi_cfg_regs #(.CFG_AW(CFG_AW), .ADDR_W(ADDR_W), .NUM_VEC(NUM_VEC)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .cfg_addr_i (cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i),
    .cfg_we_i   (cfg_we_i),
    .cfg_re_i   (cfg_re_i),
    .cfg_rdata_o(cfg_rdata_o),
    .status_i   (status),
    .db_addr_o  (db_addr),
    .enable_o   (enable),
    .mask_o     (mask),
    .clr_vec_o  (clr_vec)
  );

  msi_doorbell_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_VEC(NUM_VEC)) u_match (
    .snp_addr_i (snp_addr_i),
    .snp_data_i (snp_data_i),
    .snp_be_i   (snp_be_i),
    .snp_valid_i(snp_valid_i),
    .db_word_i  (db_addr[ADDR_W-1:2]),
    .enable_i   (enable),
    .hit_o      (hit),
    .set_vec_o  (set_vec)
  );

  msi_vector_bank #(.NUM_VEC(NUM_VEC)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .set_vec_i(set_vec),
    .clr_vec_i(clr_vec),
    .mask_i   (mask),
    .status_o (status),
    .irq_o    (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= hit;
  end

  assign snp_hit_o = hit_q;

  AST_HIT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    snp_hit_o |-> $past(enable != '0)); // R5
  AST_NEW_BIT_ENABLED: assert property (@(posedge clk) disable iff (rst)
    (status & ~$past(status) & ~$past(enable)) == '0); // R2
  AST_ONE_VECTOR_PER_BEAT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(set_vec)); // R8
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    snp_hit_o |-> $past(snp_valid_i && (&snp_be_i))); // R12

endmodule

// File: tb/msi_doorbell_ctrl_tb_top.sv
`timescale 1ns/1ps
module msi_doorbell_ctrl_tb_top;
  import msi_doorbell_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_we = 1'b0, cfg_re = 1'b0;
  logic [31:0] cfg_rdata;
  logic [63:0] snp_addr = '0;
  logic [31:0] snp_data = '0;
  logic [3:0]  snp_be = '0;
  logic        snp_valid = 1'b0;
  logic        snp_hit, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  msi_doorbell_ctrl dut_i (
    .clk(clk), .rst(rst),
    .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .cfg_we_i(cfg_we), .cfg_re_i(cfg_re),
    .cfg_rdata_o(cfg_rdata),
    .snp_addr_i(snp_addr), .snp_data_i(snp_data), .snp_be_i(snp_be), .snp_valid_i(snp_valid),
    .snp_hit_o(snp_hit), .irq_o(irq)
  );

  typedef struct {
    logic [31:0] val;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: read data appears one edge after the strobe.
  logic re_d = 1'b0;
  always @(posedge clk) re_d <= cfg_re;
  always @(negedge clk) begin
    if (re_d) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 unexpected read data actual=%h expected=none", cfg_rdata);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.tag, cfg_rdata, e.val);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic cfg_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    exp_t e;
    @(negedge clk);
    e.val = exp; e.tag = tag;
    exp_q.push_back(e);
    cfg_addr = a; cfg_re = 1'b1;
    @(negedge clk);
    cfg_re = 1'b0;
  endtask

  task automatic db(input logic [63:0] a, input logic [31:0] d, input logic [3:0] be,
                    input logic exp_hit, input string tag);
    @(negedge clk);
    snp_addr = a; snp_data = d; snp_be = be; snp_valid = 1'b1;
    @(negedge clk);
    snp_valid = 1'b0;
    chk(tag, {31'd0, snp_hit}, {31'd0, exp_hit});
  endtask

  // Register write and doorbell beat in the same cycle.
  task automatic both(input logic [11:0] ra, input logic [31:0] rd,
                      input logic [63:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    cfg_addr = ra; cfg_wdata = rd; cfg_we = 1'b1;
    snp_addr = a; snp_data = d; snp_be = 4'hF; snp_valid = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; snp_valid = 1'b0;
    chk(tag, {31'd0, snp_hit}, 32'd1);
  endtask

  localparam logic [63:0] DB = 64'h0000_00AB_1000_0040;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    tick();
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    chk("R1 hit after reset", {31'd0, snp_hit}, 32'd0);
    cfg_rd(OFS_DB_LO,  32'd0, "R1 addr low reset");
    cfg_rd(OFS_DB_HI,  32'd0, "R1 addr high reset");
    cfg_rd(OFS_ENABLE, 32'd0, "R1 enable reset");
    cfg_rd(OFS_MASK,   32'd0, "R1 mask reset");
    cfg_rd(OFS_STATUS, 32'd0, "R1 pending reset");

    // R7 halves
    cfg_wr(OFS_DB_LO, 32'h2222_0000);
    cfg_wr(OFS_DB_HI, 32'h0000_00AB);
    cfg_rd(OFS_DB_LO, 32'h2222_0000, "R7 low half");
    cfg_rd(OFS_DB_HI, 32'h0000_00AB, "R7 high half");
    cfg_wr(OFS_DB_LO, 32'h1000_0040);
    cfg_rd(OFS_DB_HI, 32'h0000_00AB, "R7 high kept after low write");
    cfg_rd(OFS_DB_LO, 32'h1000_0040, "R7 low replaced");

    // R5 window closed while enable is zero
    db(DB, 32'd3, 4'hF, 1'b0, "R5 no hit with enable zero");
    cfg_rd(OFS_STATUS, 32'd0, "R5 pending untouched");

    // R2 / R3 / R12 capture
    cfg_wr(OFS_ENABLE, 32'h8000_00F0);
    cfg_rd(OFS_ENABLE, 32'h8000_00F0, "R11 enable readback");
    db(DB, 32'd4, 4'hF, 1'b1, "R12 hit pulse vector 4");
    chk("R3 irq not yet", {31'd0, irq}, 32'd0);
    tick();
    chk("R3 irq raised", {31'd0, irq}, 32'd1);
    chk("R12 hit one cycle", {31'd0, snp_hit}, 32'd0);
    cfg_rd(OFS_STATUS, 32'h0000_0010, "R2 bit 4 set");
    db(DB, 32'd2, 4'hF, 1'b1, "R2 hit disabled vector");
    cfg_rd(OFS_STATUS, 32'h0000_0010, "R2 disabled vector not set");
    db(DB, 32'd40, 4'hF, 1'b1, "R8 hit large value");
    cfg_rd(OFS_STATUS, 32'h0000_0010, "R8 large value sets nothing");
    db(DB, 32'd31, 4'hF, 1'b1, "R2 hit vector 31");
    cfg_rd(OFS_STATUS, 32'h8000_0010, "R2 bit 31 set");

    // R6 near misses
    db(DB + 64'd4, 32'd5, 4'hF, 1'b0, "R6 next word");
    db(DB + 64'd1, 32'd5, 4'hF, 1'b0, "R6 misaligned");
    db(DB, 32'd5, 4'h7, 1'b0, "R6 partial strobes");
    db(DB ^ (64'd1 << 40), 32'd5, 4'hF, 1'b0, "R6 high half differs");
    cfg_rd(OFS_STATUS, 32'h8000_0010, "R6 pending untouched");

    // R3 / R4 masking
    cfg_wr(OFS_MASK, 32'hFFFF_FFFF);
    tick();
    chk("R3 irq low when all masked", {31'd0, irq}, 32'd0);
    db(DB, 32'd5, 4'hF, 1'b1, "R4 hit while masked");
    tick();
    chk("R4 irq stays low while masked", {31'd0, irq}, 32'd0);
    cfg_rd(OFS_STATUS, 32'h8000_0030, "R4 masked vector captured");
    cfg_rd(OFS_MASK, 32'hFFFF_FFFF, "R11 mask readback");
    cfg_wr(OFS_MASK, 32'h0);
    tick();
    chk("R4 irq after unmask", {31'd0, irq}, 32'd1);

    // R9 write-one-to-clear
    cfg_wr(OFS_STATUS, 32'h0000_0010);
    cfg_rd(OFS_STATUS, 32'h8000_0020, "R9 one bit cleared");
    cfg_wr(OFS_STATUS, 32'h0);
    cfg_rd(OFS_STATUS, 32'h8000_0020, "R9 zero write no effect");

    // R10 set beats clear
    both(OFS_STATUS, 32'h0000_0020, DB, 32'd5, "R10 hit during clear");
    cfg_rd(OFS_STATUS, 32'h8000_0020, "R10 set wins");

    // R3 deassert timing
    cfg_wr(OFS_STATUS, 32'hFFFF_FFFF);
    chk("R3 irq still high same cycle", {31'd0, irq}, 32'd1);
    tick();
    chk("R3 irq low next cycle", {31'd0, irq}, 32'd0);
    cfg_rd(OFS_STATUS, 32'h0, "R9 all cleared");

    // R11 unmapped
    cfg_rd(12'h000, 32'h0, "R11 unmapped offset 0x000");
    cfg_rd(12'h834, 32'h0, "R11 unmapped offset 0x834");

    // R5 window closes again
    cfg_wr(OFS_ENABLE, 32'h0);
    db(DB, 32'd4, 4'hF, 1'b0, "R5 no hit after disable");
    tick();
    chk("R5 irq low after disable", {31'd0, irq}, 32'd0);
    cfg_rd(OFS_STATUS, 32'h0, "R5 pending still clear");

    repeat (3) tick();
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R11 reads left unanswered actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule